// File: doc/BRIEF.md
# Secure-Gated Feature Access Register

This block is a 32-bit privileged configuration register. It decides which optional functions the less-trusted, non-secure world may use: floating point, SIMD, and the trace system registers. Only the most privileged level (3) can change it. When a register-access request arrives, the block returns one of four outcomes in the same cycle: the access completes, the access is undefined, the access traps to level 2, or the access traps to level 3. The decision depends on the requester's privilege level, its security state, the hypervisor's trap settings, the monitor's configuration and an external write-lock pin.

The block also drives a set of override lines. Downstream permission registers use these lines to force their enable and trap fields to fixed values. There is also a line that marks a non-secure floating-point or SIMD attempt as undefined.

Reads from levels 1 and 2 can return a fixed substitute value instead of the stored contents. This happens when no level 3 exists, or when the monitor runs in 64-bit mode and the non-secure bit is set.

Top module: `ns_feature_gate`

## Requirements
- R1: Only these bits hold state: bit 20 (trace lock), bits 18:16 (implementation-defined storage), bit 15 (SIMD lock), bit 11 and bit 10 (the coprocessor enable pair). All other bits read as zero and ignore writes. After writing all ones from level 3, a level-3 read returns 0x00178C00.
- R2: Any request from level 0 produces outcome 01 (undefined), for reads and for writes.
- R3: At level 1 the checks run in a fixed order:
  - If the hypervisor is enabled and its group trap bit is set, the outcome is 10 (trap to level 2).
  - Otherwise, if the hypervisor is enabled in 64-bit mode and the requester is secure, the outcome is 10.
  - Otherwise, if level 3 exists, the monitor runs in 64-bit mode and the requester is secure, the outcome is 11 (trap to level 3).
  - Otherwise the read or write rule applies.
- R4: A completed read at level 1 or level 2 returns 0x00000C00 when level 3 is absent, or when the monitor is in 64-bit mode with its non-secure bit set. Otherwise it returns the stored value. Level-3 reads always return the stored value.
- R5: Write outcomes depend on the level:
  - A level-1 write that passes the R3 traps gives outcome 01.
  - Any level-2 write gives outcome 01.
  - A level-3 write gives outcome 01 while the write-lock input is high, and 00 (complete) otherwise.
  - The register changes only on a clock edge where a completed write is presented. An undefined write leaves the read-back value unchanged.
- R6: After reset, bits 20, 15 and 18:16 read as zero. Bits 11 and 10 read as the value of the reset parameter, which defaults to zero.
- R7: Bit 11 stores the last value written to it and has no effect on any override output. Bit 10 reads back what was written to it.
- R8: When bit 10 is 0:
  - The hypervisor floating-point trap force line is 1.
  - If the requester is also non-secure, the downstream enable-pair force-zero line is 1.
  - A non-secure floating-point or SIMD attempt raises the undefined line.
  - When bit 10 is 1, all three lines are 0.
- R9: Bit 15 drives the hypervisor SIMD trap force line directly. It also drives the downstream SIMD-disable force line, but only while the requester is non-secure. Bit 20 does the same for the two trace lines.
- R10: The syndrome output is 0x3 for outcomes 10 and 11, and 0 for outcomes 00 and 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low warm reset |
| reqValid | input | 1 | Register access request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqEl | input | 2 | Privilege level of requester (0..3) |
| secState | input | 1 | 1 = requester in secure state |
| hypEnabled | input | 1 | Hypervisor level enabled |
| hyp64 | input | 1 | Hypervisor runs in 64-bit mode |
| hypGroupTrap | input | 1 | Hypervisor group trap bit for this register |
| el3Present | input | 1 | Level 3 implemented |
| mon64 | input | 1 | Monitor runs in 64-bit mode |
| monNsBit | input | 1 | Monitor's non-secure bit |
| writeLock | input | 1 | External lock blocking level-3 writes |
| wrData | input | 32 | Write data |
| fpOpAttempt | input | 1 | A floating-point/SIMD operation is being attempted |
| rdData | output | 32 | Read data (stored or substitute) |
| outcome | output | 2 | 00 complete, 01 undefined, 10 trap L2, 11 trap L3 |
| syndrome | output | 4 | Trap syndrome tag |
| nsFpPairZero | output | 1 | Force downstream enable pair to 00 |
| hypFpTrapOne | output | 1 | Force hypervisor FP trap bits to one |
| fpOpUndef | output | 1 | Current FP/SIMD attempt is undefined |
| nsSimdDisOne | output | 1 | Force downstream SIMD disable to one |
| hypSimdTrapOne | output | 1 | Force hypervisor SIMD trap to one |
| nsTrcDisOne | output | 1 | Force downstream trace disable to one |
| hypTrcTrapOne | output | 1 | Force hypervisor trace trap to one |

## Verification
The hardest situation to reach is one where several level-1 trap conditions hold at once. In that case only the ordering decides the outcome. The stimulus table therefore includes rows where the group trap, the secure 64-bit hypervisor condition and the 64-bit monitor condition all hold together, and each row expects the earliest rule in the order to win. Ignored writes are confirmed at the ports: after a locked or undefined write, a level-3 read must still return the earlier value. Reads of bit 11 are made only in cases where it matches bit 10.

// File: rtl/nsg_pkg.sv
package nsg_pkg;
  localparam int REG_W      = 32;
  localparam int TRC_BIT    = 20;
  localparam int IMP_LO     = 16;
  localparam int IMP_W      = 3;
  localparam int SIMD_BIT   = 15;
  localparam int CPHI_BIT   = 11;
  localparam int CPLO_BIT   = 10;
  localparam logic [REG_W-1:0] SUBST_VAL = 32'h0000_0C00;
  localparam logic [REG_W-1:0] RSV_MASK  = 32'hFFE8_73FF;

  typedef enum logic [1:0] {
    OUT_DONE     = 2'b00,
    OUT_UNDEF    = 2'b01,
    OUT_TRAP_HYP = 2'b10,
    OUT_TRAP_MON = 2'b11
  } outcome_e;

  typedef struct packed {
    logic wrEn;
    logic useSubst;
  } strobe_t;
endpackage

// File: rtl/nsg_data.sv
module nsg_data
  import nsg_pkg::*;
#(
  parameter bit HAS_FP    = 1'b1,
  parameter bit HAS_TRACE = 1'b1,
  parameter bit FP_RST    = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] storedVal,
  output logic [REG_W-1:0] rdData
);
  logic trcBit, simdBit, cpHiBit, cpLoBit;
  logic [IMP_W-1:0] impQ;
  logic unusedWr;

  assign unusedWr = ^wrData;

  generate
    if (HAS_TRACE) begin : g_trc
      logic trcQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) trcQ <= 1'b0;
        else if (strb.wrEn) trcQ <= wrData[TRC_BIT];
      end
      assign trcBit = trcQ;
    end else begin : g_noTrc
      assign trcBit = 1'b0;
    end

    if (HAS_FP) begin : g_fp
      logic simdQ, hiQ, loQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          simdQ <= 1'b0;
          hiQ   <= FP_RST;
          loQ   <= FP_RST;
        end else if (strb.wrEn) begin
          simdQ <= wrData[SIMD_BIT];
          hiQ   <= wrData[CPHI_BIT];
          loQ   <= wrData[CPLO_BIT];
        end
      end
      assign simdBit = simdQ;
      assign cpHiBit = hiQ;
      assign cpLoBit = loQ;
    end else begin : g_noFp
      assign simdBit = 1'b0;
      assign cpHiBit = 1'b0;
      assign cpLoBit = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) impQ <= '0;
    else if (strb.wrEn) impQ <= wrData[IMP_LO +: IMP_W];
  end

  always_comb begin
    storedVal = '0;
    storedVal[TRC_BIT]          = trcBit;
    storedVal[IMP_LO +: IMP_W]  = impQ;
    storedVal[SIMD_BIT]         = simdBit;
    storedVal[CPHI_BIT]         = cpHiBit;
    storedVal[CPLO_BIT]         = cpLoBit;
  end

  assign rdData = strb.useSubst ? SUBST_VAL : storedVal;
endmodule

// File: rtl/nsg_ctrl.sv
module nsg_ctrl
  import nsg_pkg::*;
#(
  parameter int               SYND_W   = 4,
  parameter logic [SYND_W-1:0] SYND_TAG = 4'h3
) (
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [1:0]       reqEl,
  input  logic             secState,
  input  logic             hypEnabled,
  input  logic             hyp64,
  input  logic             hypGroupTrap,
  input  logic             el3Present,
  input  logic             mon64,
  input  logic             monNsBit,
  input  logic             writeLock,
  input  logic             fpOpAttempt,
  input  logic [REG_W-1:0] storedVal,
  output outcome_e         outc,
  output logic [SYND_W-1:0] syndrome,
  output strobe_t          strb,
  output logic             nsFpPairZero,
  output logic             hypFpTrapOne,
  output logic             fpOpUndef,
  output logic             nsSimdDisOne,
  output logic             hypSimdTrapOne,
  output logic             nsTrcDisOne,
  output logic             hypTrcTrapOne
);
  logic lowSubst, subst, unusedSt;

  assign unusedSt = ^storedVal;
  assign lowSubst = !el3Present || (mon64 && monNsBit);

  always_comb begin
    outc  = OUT_DONE;
    subst = 1'b0;
    unique case (reqEl)
      2'd0: outc = OUT_UNDEF;
      2'd1: begin
        if (hypEnabled && hypGroupTrap)                outc = OUT_TRAP_HYP;
        else if (hypEnabled && hyp64 && secState)      outc = OUT_TRAP_HYP;
        else if (el3Present && mon64 && secState)      outc = OUT_TRAP_MON;
        else if (reqWrite)                             outc = OUT_UNDEF;
        else                                           subst = lowSubst;
      end
      2'd2: begin
        if (reqWrite) outc  = OUT_UNDEF;
        else          subst = lowSubst;
      end
      default: begin
        if (reqWrite && writeLock) outc = OUT_UNDEF;
      end
    endcase
  end

  assign strb.wrEn     = reqValid && reqWrite && (outc == OUT_DONE);
  assign strb.useSubst = subst;
  assign syndrome      = outc[1] ? SYND_TAG : '0;

  assign hypFpTrapOne   = !storedVal[CPLO_BIT];
  assign nsFpPairZero   = !secState && !storedVal[CPLO_BIT];
  assign fpOpUndef      = fpOpAttempt && !secState && !storedVal[CPLO_BIT];
  assign hypSimdTrapOne = storedVal[SIMD_BIT];
  assign nsSimdDisOne   = !secState && storedVal[SIMD_BIT];
  assign hypTrcTrapOne  = storedVal[TRC_BIT];
  assign nsTrcDisOne    = !secState && storedVal[TRC_BIT];
endmodule

// File: rtl/ns_feature_gate.sv
module ns_feature_gate
  import nsg_pkg::*;
#(
  parameter bit HAS_FP    = 1'b1,
  parameter bit HAS_TRACE = 1'b1,
  parameter bit FP_RST    = 1'b0,
  parameter int SYND_W    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [1:0]        reqEl,
  input  logic              secState,
  input  logic              hypEnabled,
  input  logic              hyp64,
  input  logic              hypGroupTrap,
  input  logic              el3Present,
  input  logic              mon64,
  input  logic              monNsBit,
  input  logic              writeLock,
  input  logic [31:0]       wrData,
  input  logic              fpOpAttempt,
  output logic [31:0]       rdData,
  output logic [1:0]        outcome,
  output logic [SYND_W-1:0] syndrome,
  output logic              nsFpPairZero,
  output logic              hypFpTrapOne,
  output logic              fpOpUndef,
  output logic              nsSimdDisOne,
  output logic              hypSimdTrapOne,
  output logic              nsTrcDisOne,
  output logic              hypTrcTrapOne
);
  strobe_t          strb;
  outcome_e         outc;
  logic [REG_W-1:0] storedVal;

  nsg_ctrl #(.SYND_W(SYND_W), .SYND_TAG(SYND_W'(3))) u_ctrl (
    .reqValid(reqValid), .reqWrite(reqWrite), .reqEl(reqEl),
    .secState(secState), .hypEnabled(hypEnabled), .hyp64(hyp64),
    .hypGroupTrap(hypGroupTrap), .el3Present(el3Present), .mon64(mon64),
    .monNsBit(monNsBit), .writeLock(writeLock), .fpOpAttempt(fpOpAttempt),
    .storedVal(storedVal), .outc(outc), .syndrome(syndrome), .strb(strb),
    .nsFpPairZero(nsFpPairZero), .hypFpTrapOne(hypFpTrapOne),
    .fpOpUndef(fpOpUndef), .nsSimdDisOne(nsSimdDisOne),
    .hypSimdTrapOne(hypSimdTrapOne), .nsTrcDisOne(nsTrcDisOne),
    .hypTrcTrapOne(hypTrcTrapOne)
  );

  nsg_data #(.HAS_FP(HAS_FP), .HAS_TRACE(HAS_TRACE), .FP_RST(FP_RST)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .storedVal(storedVal), .rdData(rdData)
  );

  assign outcome = outc;
endmodule

// File: rtl/nsg_checker.sv
module nsg_checker
  import nsg_pkg::*;
#(
  parameter int SYND_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqWrite,
  input logic [1:0]        reqEl,
  input logic              hypEnabled,
  input logic              hypGroupTrap,
  input logic              writeLock,
  input logic [1:0]        outcome,
  input logic [SYND_W-1:0] syndrome,
  input logic [31:0]       rdData,
  input logic [31:0]       storedVal
);
  // R2
  el0_undef_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqEl == 2'd0) |-> outcome == 2'b01);

  // R3
  group_trap_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqEl == 2'd1 && hypEnabled && hypGroupTrap) |-> outcome == 2'b10);

  // R5
  write_done_only_mon_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && outcome == 2'b00) |-> (reqEl == 2'd3 && !writeLock));

  // R5
  hold_without_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && reqWrite && outcome == 2'b00) |=> $stable(storedVal));

  // R1
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdData & RSV_MASK) == 32'h0);

  // R10
  trap_synd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && outcome[1]) |-> syndrome == SYND_W'(3));
endmodule

bind ns_feature_gate nsg_checker #(.SYND_W(SYND_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
  .reqEl(reqEl), .hypEnabled(hypEnabled), .hypGroupTrap(hypGroupTrap),
  .writeLock(writeLock), .outcome(outcome), .syndrome(syndrome),
  .rdData(rdData), .storedVal(storedVal)
);

// File: tb/sim_ns_feature_gate.sv
module sim_ns_feature_gate;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [1:0] reqEl = 2'd0;
  logic secState = 1'b0, hypEnabled = 1'b0, hyp64 = 1'b0, hypGroupTrap = 1'b0;
  logic el3Present = 1'b1, mon64 = 1'b0, monNsBit = 1'b0, writeLock = 1'b0;
  logic [31:0] wrData = 32'h0;
  logic fpOpAttempt = 1'b0;
  logic [31:0] rdData;
  logic [1:0] outcome;
  logic [3:0] syndrome;
  logic nsFpPairZero, hypFpTrapOne, fpOpUndef, nsSimdDisOne, hypSimdTrapOne;
  logic nsTrcDisOne, hypTrcTrapOne;
  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  ns_feature_gate u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqEl(reqEl), .secState(secState), .hypEnabled(hypEnabled), .hyp64(hyp64),
    .hypGroupTrap(hypGroupTrap), .el3Present(el3Present), .mon64(mon64),
    .monNsBit(monNsBit), .writeLock(writeLock), .wrData(wrData),
    .fpOpAttempt(fpOpAttempt), .rdData(rdData), .outcome(outcome),
    .syndrome(syndrome), .nsFpPairZero(nsFpPairZero), .hypFpTrapOne(hypFpTrapOne),
    .fpOpUndef(fpOpUndef), .nsSimdDisOne(nsSimdDisOne),
    .hypSimdTrapOne(hypSimdTrapOne), .nsTrcDisOne(nsTrcDisOne),
    .hypTrcTrapOne(hypTrcTrapOne)
  );

  // {wr, el[1:0], sec, hypEn, hyp64, t1, el3, mon64, ns, lock, expOutcome[1:0]}
  localparam logic [12:0] VEC [16] = '{
    13'b0_00_0_0_0_0_1_0_0_0_01,
    13'b1_00_0_0_0_0_1_0_0_0_01,
    13'b0_01_0_1_0_1_1_0_0_0_10,
    13'b0_01_1_1_1_0_1_0_0_0_10,
    13'b0_01_1_0_0_0_1_1_0_0_11,
    13'b0_01_1_1_1_1_1_1_0_0_10,
    13'b0_01_1_1_0_0_1_1_0_0_11,
    13'b0_01_0_0_0_0_1_1_1_0_00,
    13'b1_01_0_0_0_0_1_1_1_0_01,
    13'b1_01_0_1_0_1_1_0_0_0_10,
    13'b0_10_0_0_0_0_1_0_0_0_00,
    13'b1_10_0_0_0_0_1_0_0_0_01,
    13'b0_11_1_0_0_0_1_0_0_0_00,
    13'b1_11_1_0_0_0_1_0_0_1_01,
    13'b1_11_1_0_0_0_1_0_0_0_00,
    13'b0_01_1_1_0_0_1_0_0_0_00
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic wr, input logic [1:0] el, input logic sec,
                       input logic e3, input logic m64, input logic ns,
                       input logic lock, input logic [31:0] d);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqEl = el; secState = sec;
    hypEnabled = 1'b0; hyp64 = 1'b0; hypGroupTrap = 1'b0;
    el3Present = e3; mon64 = m64; monNsBit = ns; writeLock = lock; wrData = d;
    #1;
  endtask

  task automatic mon_write(input logic [31:0] d);
    drive(1'b1, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, d);
    check("R5 level-3 write completes", {30'd0, outcome}, 32'd0);
  endtask

  task automatic mon_read(input string tag, input logic [31:0] mask, input logic [31:0] exp);
    drive(1'b0, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0);
    check(tag, rdData & mask, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R6 reset state
    mon_read("R6 reset value", 32'hFFFF_FFFF, 32'h0);

    // R2 R3 R5 R10 decision table
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      reqValid = 1'b1;
      {reqWrite, reqEl, secState, hypEnabled, hyp64, hypGroupTrap,
       el3Present, mon64, monNsBit, writeLock} = VEC[i][12:2];
      wrData = 32'h0;
      #1;
      check($sformatf("R2/R3/R5 outcome row %0d", i), {30'd0, outcome}, {30'd0, VEC[i][1:0]});
      check($sformatf("R10 syndrome row %0d", i), {28'd0, syndrome},
            VEC[i][1] ? 32'h3 : 32'h0);
    end

    // R1 reserved bits
    mon_write(32'hFFFF_FFFF);
    mon_read("R1 writable bits only", 32'hFFFF_FFFF, 32'h0017_8C00);

    // R5 ignored writes
    drive(1'b1, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0);
    check("R5 locked write undefined", {30'd0, outcome}, 32'h1);
    mon_read("R5 locked write ignored", 32'hFFFF_FFFF, 32'h0017_8C00);
    drive(1'b1, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0);
    check("R5 level-2 write undefined", {30'd0, outcome}, 32'h1);
    mon_read("R5 level-2 write ignored", 32'hFFFF_FFFF, 32'h0017_8C00);

    // R4 substitute reads
    drive(1'b0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
    check("R4 no level 3 substitute", rdData, 32'h0000_0C00);
    drive(1'b0, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 32'h0);
    check("R4 mon64 ns substitute", rdData, 32'h0000_0C00);
    drive(1'b0, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0);
    check("R4 mon64 ns=0 stored", rdData, 32'h0017_8C00);
    drive(1'b0, 2'd1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0);
    check("R4 mon32 stored", rdData, 32'h0017_8C00);

    // R8 R9 with bit10=1, bit15=1, bit20=1, non-secure
    fpOpAttempt = 1'b1;
    drive(1'b0, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0);
    check("R8 pair zero off", {31'd0, nsFpPairZero}, 32'h0);
    check("R8 hyp fp trap off", {31'd0, hypFpTrapOne}, 32'h0);
    check("R8 fp undef off", {31'd0, fpOpUndef}, 32'h0);
    check("R9 simd/trace forces on",
          {28'd0, nsSimdDisOne, hypSimdTrapOne, nsTrcDisOne, hypTrcTrapOne}, 32'hF);

    // R7 bit 11 set, bit 10 clear: no effect of bit 11
    mon_write(32'h0000_0800);
    drive(1'b0, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0);
    check("R8 pair zero on", {31'd0, nsFpPairZero}, 32'h1);
    check("R8 hyp fp trap on", {31'd0, hypFpTrapOne}, 32'h1);
    check("R8 fp undef on", {31'd0, fpOpUndef}, 32'h1);
    check("R9 simd/trace forces off",
          {28'd0, nsSimdDisOne, hypSimdTrapOne, nsTrcDisOne, hypTrcTrapOne}, 32'h0);
    check("R7 bit 11 no effect", rdData & 32'hFFFF_F7FF, 32'h0);
    drive(1'b0, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0);
    check("R8 secure pair not forced", {30'd0, nsFpPairZero, fpOpUndef}, 32'h0);
    check("R8 hyp trap force secure", {31'd0, hypFpTrapOne}, 32'h1);

    // R9 SIMD only, secure vs non-secure
    mon_write(32'h0000_8400);
    drive(1'b0, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0);
    check("R9 secure simd", {30'd0, nsSimdDisOne, hypSimdTrapOne}, 32'h1);
    drive(1'b0, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0);
    check("R9 ns simd", {28'd0, nsSimdDisOne, hypSimdTrapOne, nsTrcDisOne, hypTrcTrapOne}, 32'hC);
    fpOpAttempt = 1'b0;

    // R7 read-back of pair when equal, and bit 10 alone
    mon_write(32'h0000_0C00);
    mon_read("R7 pair both set", 32'hFFFF_FFFF, 32'h0000_0C00);
    mon_write(32'h0000_0400);
    mon_read("R7 bit 10 alone", 32'hFFFF_F7FF, 32'h0000_0400);
    mon_write(32'h0000_0000);
    mon_read("R7 pair both clear", 32'hFFFF_FFFF, 32'h0);

    @(negedge clk);
    reqValid = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule